// File: doc/BRIEF.md
# Configurable UART Framer

This block is a matched pair of UART serialisers: a transmitter that turns a byte into an asynchronous frame, and a receiver that turns a frame on the line back into a byte with status. Both run from a shared strobe `tick_i` that pulses sixteen times per bit period, so one bit lasts exactly sixteen ticks. The baud generator, queues and flow control are outside the block.

Frame format comes from a 7-bit line control input. It selects word length (5 to 8 bits, least significant bit first), a long stop period, parity on or off, even or odd sense, and a forced parity value that serves as the ninth bit in multidrop addressing. A seventh bit pulls the transmit line to the spacing (low) level for as long as it is set. Each engine copies the format at the start of a frame, so a format change never damages a frame already on the line. The receiver holds one byte with its parity, framing and break flags until it is read, and raises an overrun flag when a newer byte replaces one that was never read.

Top module: `uart_framer`

## Requirements
- R1: `lcr_i[1:0]` sets the word length (00→5, 01→6, 10→7, 11→8 bits). Data bits go on the line least significant first, after a low start bit. The line is high when idle. Unused upper bits of `rx_data_o` read as zero.
- R2: With `lcr_i[2]` low the stop period is 16 ticks. With it high the stop period is 24 ticks for 5-bit words and 32 ticks for other lengths. `tx_ready_o` stays low for 16·(1 + word length + parity) + stop ticks after a byte is accepted.
- R3: `lcr_i[3]` adds a parity bit after the data. With `lcr_i[4]` high the bit is the XOR of the data bits (even parity). With `lcr_i[4]` low it is the inverse of that XOR (odd parity).
- R4: When `lcr_i[3]` and `lcr_i[5]` are both high, the parity bit is forced to 1 if `lcr_i[4]` is low and to 0 if it is high, whatever the data.
- R5: While `lcr_i[6]` is high, `tx_o` is low. When it is cleared the line returns to its idle or frame level.
- R6: The receiver starts a frame on a low line at a tick and confirms it on the eighth tick. If the line is high again by then, the frame is abandoned with no output. Each later bit is sampled on the eighth tick of its sixteen.
- R7: `rx_parity_err_o` is set with a received byte when parity is enabled and the received parity bit differs from the value R3/R4 gives for the received data.
- R8: `rx_frame_err_o` is set with a received byte whose first stop bit is sampled low.
- R9: When the start bit, every data bit, any parity bit and the stop bit are all low, `rx_break_o` and `rx_frame_err_o` are both set. The receiver then waits for the line to go high before it looks for a new start bit.
- R10: A byte is delivered when its first stop bit is sampled. It sets `rx_valid_o`. If `rx_valid_o` was already set and `rx_read_i` is low in that cycle, `rx_overrun_o` is set and the new byte replaces the old one. A read in the same cycle as a delivery consumes the old byte and gives no overrun. A read in any other cycle clears `rx_valid_o` and `rx_overrun_o`.
- R11: After reset `tx_o` is high, `tx_ready_o` is high, and `rx_valid_o` and all receive flags are low.
- R12: A byte is accepted only in a cycle where `tx_valid_i` and `tx_ready_o` are both high. With `tx_valid_i` low an idle transmitter stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling strobe, 16 per bit |
| lcr_i | input | 7 | Line control: length[1:0], long stop[2], parity en[3], even[4], force[5], break[6] |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Transmitter idle, byte will be taken |
| tx_o | output | 1 | Serial output |
| rx_i | input | 1 | Serial input |
| rx_read_i | input | 1 | Consumes the held received byte |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte held |
| rx_parity_err_o | output | 1 | Parity mismatch on held byte |
| rx_frame_err_o | output | 1 | Stop bit low on held byte |
| rx_break_o | output | 1 | Held frame was all low |
| rx_overrun_o | output | 1 | A held byte was replaced unread |

## Verification
The two receiver actions that can fall in the same cycle are delivery of a new byte and a read of the held one. The bench drives the serial input itself, one value per clock, and raises `rx_read_i` only for the exact cycle in which the first stop bit is sampled. It then expects the new byte to be held with no overrun. A second run, with no read at all, must instead show the overrun flag with the newer byte on `rx_data_o`.

// File: rtl/uart_framer_pkg.sv
package uart_framer_pkg;

  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic       brk;
    logic       force_par;
    logic       even;
    logic       par_en;
    logic       stop_long;
    logic [1:0] len;
  } line_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } frm_state_e;

  function automatic logic [DATA_W-1:0] len_mask(line_cfg_t c);
    return 8'hFF >> (2'd3 - c.len);
  endfunction

  function automatic logic par_value(line_cfg_t c, logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] m;
    m = d & len_mask(c);
    if (c.force_par) return ~c.even;
    return c.even ? ^m : ~^m;
  endfunction

  // stop period in ticks: 1, 1.5 (5-bit words) or 2 bits
  function automatic int unsigned stop_ticks(line_cfg_t c, int unsigned osr);
    if (!c.stop_long) return osr;
    if (c.len == 2'd0) return osr + osr / 2;
    return 2 * osr;
  endfunction

endpackage

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_framer_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  line_cfg_t         lcr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              tx_o
);
  localparam int unsigned SCW = $clog2(2 * OSR);
  localparam int unsigned BW  = $clog2(DATA_W);

  frm_state_e        state_q;
  logic [SCW-1:0]    tcnt_q;
  logic [BW-1:0]     bidx_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  line_cfg_t         cfg_q;
  logic              bit_end, stop_end, last_bit, line;

  assign bit_end  = tcnt_q == SCW'(OSR - 1);
  assign stop_end = tcnt_q == SCW'(stop_ticks(cfg_q, OSR) - 1);
  assign last_bit = bidx_q == BW'(4 + cfg_q.len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      cfg_q   <= '0;
    end else if (state_q == ST_IDLE) begin
      if (valid_i) begin
        cfg_q   <= lcr_i;
        sh_q    <= data_i;
        par_q   <= par_value(lcr_i, data_i);
        tcnt_q  <= '0;
        state_q <= ST_START;
      end
    end else if (tick_i) begin
      tcnt_q <= tcnt_q + 1'b1;
      unique case (state_q)
        ST_START: if (bit_end) begin
          tcnt_q  <= '0;
          bidx_q  <= '0;
          state_q <= ST_DATA;
        end
        ST_DATA: if (bit_end) begin
          tcnt_q <= '0;
          sh_q   <= sh_q >> 1;
          bidx_q <= bidx_q + 1'b1;
          if (last_bit) state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (bit_end) begin
          tcnt_q  <= '0;
          state_q <= ST_STOP;
        end
        ST_STOP: if (stop_end) begin
          tcnt_q  <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh_q[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  assign ready_o = state_q == ST_IDLE;
  // break level follows the live control bit, not the latched copy
  assign tx_o    = line & ~lcr_i.brk;

  AST_READY_FELL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(valid_i));  // R12
  AST_BIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DATA |-> bidx_q <= BW'(4 + cfg_q.len));  // R1
  AST_STOP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_STOP |-> tcnt_q <= SCW'(stop_ticks(cfg_q, OSR) - 1));  // R2

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_framer_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  line_cfg_t         lcr_i,
  input  logic              rx_i,
  input  logic              read_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o,
  output logic              ovr_o
);
  localparam int unsigned CW   = $clog2(OSR);
  localparam int unsigned BW   = $clog2(DATA_W);
  localparam int unsigned HALF = OSR / 2;

  frm_state_e        state_q;
  logic [CW-1:0]     tcnt_q;
  logic [BW-1:0]     bidx_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  line_cfg_t         cfg_q;
  logic              mid, bit_end, last_bit, done, all_low;
  logic              unused_brk;

  assign unused_brk = cfg_q.brk;
  assign mid      = tcnt_q == CW'(HALF - 1);
  assign bit_end  = tcnt_q == CW'(OSR - 1);
  assign last_bit = bidx_q == BW'(4 + cfg_q.len);
  assign done     = tick_i && state_q == ST_STOP && mid;
  assign all_low  = !rx_i && sh_q == '0 && !(cfg_q.par_en && par_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      cfg_q   <= '0;
    end else if (tick_i) begin
      tcnt_q <= tcnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          tcnt_q <= '0;
          if (!rx_i) begin
            cfg_q   <= lcr_i;
            sh_q    <= '0;
            par_q   <= 1'b0;
            state_q <= ST_START;
          end
        end
        ST_START: begin
          if (mid && rx_i) begin
            tcnt_q  <= '0;
            state_q <= ST_IDLE;  // glitch, not a start bit
          end else if (bit_end) begin
            tcnt_q  <= '0;
            bidx_q  <= '0;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (mid) sh_q[bidx_q] <= rx_i;
          if (bit_end) begin
            tcnt_q <= '0;
            bidx_q <= bidx_q + 1'b1;
            if (last_bit) state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: begin
          if (mid) par_q <= rx_i;
          if (bit_end) begin
            tcnt_q  <= '0;
            state_q <= ST_STOP;
          end
        end
        ST_STOP: if (mid) begin
          tcnt_q  <= '0;
          state_q <= rx_i ? ST_IDLE : ST_HOLD;
        end
        ST_HOLD: begin
          tcnt_q <= '0;
          if (rx_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      brk_o   <= 1'b0;
      ovr_o   <= 1'b0;
    end else if (done) begin
      data_o  <= sh_q;
      valid_o <= 1'b1;
      perr_o  <= cfg_q.par_en && (par_q != par_value(cfg_q, sh_q));
      ferr_o  <= !rx_i;
      brk_o   <= all_low;
      ovr_o   <= valid_o && !read_i;
    end else if (read_i) begin
      valid_o <= 1'b0;
      ovr_o   <= 1'b0;
    end
  end

  AST_BRK_FE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> ferr_o);  // R9
  AST_OVR_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> valid_o && $past(valid_o));  // R10
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && !done) |=> !valid_o && !ovr_o);  // R10
  AST_HOLD_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !rx_i) |=> state_q == ST_HOLD);  // R9

endmodule

// File: rtl/uart_framer.sv
module uart_framer
  import uart_framer_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [6:0]        lcr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              tx_o,
  input  logic              rx_i,
  input  logic              rx_read_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_parity_err_o,
  output logic              rx_frame_err_o,
  output logic              rx_break_o,
  output logic              rx_overrun_o
);
  line_cfg_t cfg;
  assign cfg = line_cfg_t'(lcr_i);

  uart_tx_engine #(.OSR(OSR)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .lcr_i   (cfg),
    .data_i  (tx_data_i),
    .valid_i (tx_valid_i),
    .ready_o (tx_ready_o),
    .tx_o    (tx_o)
  );

  uart_rx_engine #(.OSR(OSR)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .lcr_i   (cfg),
    .rx_i    (rx_i),
    .read_i  (rx_read_i),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o),
    .perr_o  (rx_parity_err_o),
    .ferr_o  (rx_frame_err_o),
    .brk_o   (rx_break_o),
    .ovr_o   (rx_overrun_o)
  );

  AST_BREAK_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lcr_i[6]) && lcr_i[6]) |-> !tx_o);  // R5

endmodule

// File: tb/uart_framer_tb_top.sv
module uart_framer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] lcr = 7'h03;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready, tx_line;
  logic       loop_en = 1'b1;
  logic       rx_drv = 1'b1;
  logic       rx_read = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_perr, rx_ferr, rx_brk, rx_ovr;
  logic       rx_line;
  int         checks = 0;
  int         fails = 0;
  bit         finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign rx_line = loop_en ? tx_line : rx_drv;

  uart_framer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .lcr_i(lcr),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_o(tx_line), .rx_i(rx_line), .rx_read_i(rx_read),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_parity_err_o(rx_perr),
    .rx_frame_err_o(rx_ferr), .rx_break_o(rx_brk), .rx_overrun_o(rx_ovr)
  );

  // {lcr, data}
  localparam logic [14:0] VEC [9] = '{
    {7'h03, 8'hA5}, {7'h00, 8'h13}, {7'h1B, 8'h3C}, {7'h0A, 8'h55},
    {7'h07, 8'h81}, {7'h04, 8'h1F}, {7'h2B, 8'h00}, {7'h3B, 8'hFF},
    {7'h0D, 8'h2A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input logic [6:0] c);
    return 8'hFF >> (3 - c[1:0]);
  endfunction

  function automatic logic exp_par(input logic [6:0] c, input logic [7:0] d);
    if (c[5]) return !c[4];
    return c[4] ? ^(d & mask_of(c)) : !(^(d & mask_of(c)));
  endfunction

  function automatic int exp_len(input logic [6:0] c);
    int nb = 5 + c[1:0];
    int st = !c[2] ? 16 : (c[1:0] == 0 ? 24 : 32);
    return 16 * (1 + nb + c[3]) + st;
  endfunction

  function automatic logic [15:0] mk(input logic [7:0] d, input int nb, input bit pe,
                                     input bit pb, input bit sb);
    logic [15:0] v = '1;
    v[0] = 1'b0;
    for (int i = 0; i < nb; i++) v[1+i] = d[i];
    if (pe) v[1+nb] = pb;
    v[1+nb+pe] = sb;
    return v;
  endfunction

  task automatic tx_frame(input logic [6:0] c, input logic [7:0] d,
                          output logic [7:0] dq, output logic pq, output logic sq,
                          output logic st, output int len);
    int nb = 5 + c[1:0];
    int pe = c[3];
    int cyc = 0;
    dq = '0; pq = 1'bx; sq = 1'bx; st = 1'bx; len = 0;
    @(negedge clk);
    lcr = c; tx_data = d; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    while (!tx_ready && len < 400) begin
      len++;
      if (cyc % 16 == 8) begin
        if (cyc / 16 == 0) st = tx_line;
        else if (cyc / 16 <= nb) dq[cyc/16-1] = tx_line;
        else if (pe == 1 && cyc / 16 == nb + 1) pq = tx_line;
        else if (cyc / 16 == nb + 1 + pe) sq = tx_line;
      end
      cyc++;
      @(negedge clk);
    end
  endtask

  // one line value per clock, 16 clocks per bit; read pulse at cycle rd_at
  task automatic rx_drive(input logic [15:0] bits, input int rd_at, input bit skew);
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      rx_drv  = bits[c/16];
      if (skew && (c % 16 < 3 || c % 16 > 12)) rx_drv = ~bits[c/16];
      rx_read = (c == rd_at);
    end
    @(negedge clk);
    rx_drv = 1'b1; rx_read = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); rx_read = 1'b1;
    @(negedge clk); rx_read = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] dq;
    logic pq, sq, st;
    int len;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 tx_o", tx_line, 1);
    chk("R11 tx_ready", tx_ready, 1);
    chk("R11 rx_valid", rx_valid, 0);
    chk("R11 flags", {rx_perr, rx_ferr, rx_brk, rx_ovr}, 0);
    rst_n = 1'b1;
    idle(4);

    // R12 no valid: stays idle
    idle(40);
    chk("R12 idle ready", tx_ready, 1);
    chk("R12 idle line", tx_line, 1);

    // table walk in loopback
    for (int k = 0; k < 9; k++) begin
      logic [6:0] c = VEC[k][14:8];
      logic [7:0] d = VEC[k][7:0];
      tx_frame(c, d, dq, pq, sq, st, len);
      chk("R1 start low", st, 0);
      chk("R1 tx data", dq, d & mask_of(c));
      if (c[3]) chk(c[5] ? "R4 forced parity" : "R3 parity bit", pq, exp_par(c, d));
      chk("R2 stop high", sq, 1);
      chk("R2 frame length", len, exp_len(c));
      chk("R1 rx valid", rx_valid, 1);
      chk("R1 rx data", rx_data, d & mask_of(c));
      chk("R7 clean flags", {rx_perr, rx_ferr, rx_brk, rx_ovr}, 0);
      do_read();
      chk("R10 read clears", rx_valid, 0);
    end

    // R5 transmit break
    loop_en = 1'b0;
    @(negedge clk); lcr = 7'h43;
    idle(20);
    chk("R5 break low", tx_line, 0);
    idle(20);
    chk("R5 break held", tx_line, 0);
    lcr = 7'h03;
    @(negedge clk);
    chk("R5 break released", tx_line, 1);

    // R7 parity error: 8E, data 3C expects 0, send 1
    lcr = 7'h1B;
    rx_drive(mk(8'h3C, 8, 1, 1, 1), -1, 0);
    chk("R7 valid", rx_valid, 1);
    chk("R7 data", rx_data, 8'h3C);
    chk("R7 parity err", rx_perr, 1);
    chk("R8 no frame err", rx_ferr, 0);
    do_read();

    // R8 framing error
    lcr = 7'h03;
    rx_drive(mk(8'h5A, 8, 0, 0, 0), -1, 0);
    chk("R8 frame err", rx_ferr, 1);
    chk("R8 data", rx_data, 8'h5A);
    chk("R9 no break", rx_brk, 0);
    do_read();

    // R9 break, line held low beyond the frame
    rx_drive(16'h0000, -1, 0);
    chk("R9 break", rx_brk, 1);
    chk("R9 frame err", rx_ferr, 1);
    chk("R9 data zero", rx_data, 0);
    do_read();
    idle(100);
    chk("R9 no extra frame", rx_valid, 0);
    rx_drive(mk(8'h77, 8, 0, 0, 1), -1, 0);
    chk("R9 next byte", rx_data, 8'h77);
    chk("R9 break cleared", {rx_brk, rx_ferr}, 0);
    do_read();

    // R6 short glitch is not a start bit
    @(negedge clk); rx_drv = 1'b0;
    idle(4);
    rx_drv = 1'b1;
    idle(200);
    chk("R6 glitch ignored", rx_valid, 0);
    // R6 bit edges corrupted, mid-bit sampling recovers
    rx_drive(mk(8'h96, 8, 0, 0, 1), -1, 1);
    chk("R6 mid-bit sample", rx_data, 8'h96);
    chk("R6 valid", rx_valid, 1);
    do_read();

    // R10 overrun
    rx_drive(mk(8'h11, 8, 0, 0, 1), -1, 0);
    rx_drive(mk(8'h22, 8, 0, 0, 1), -1, 0);
    chk("R10 overrun", rx_ovr, 1);
    chk("R10 newest data", rx_data, 8'h22);
    do_read();
    chk("R10 read clears ovr", {rx_valid, rx_ovr}, 0);
    // R10 read coincides with delivery (stop sampled at cycle 152)
    rx_drive(mk(8'h33, 8, 0, 0, 1), -1, 0);
    rx_drive(mk(8'h44, 8, 0, 0, 1), 152, 0);
    chk("R10 same-cycle valid", rx_valid, 1);
    chk("R10 same-cycle data", rx_data, 8'h44);
    chk("R10 same-cycle no ovr", rx_ovr, 0);
    do_read();

    // R1 5-bit receive masks upper bits
    lcr = 7'h00;
    rx_drive(mk(8'hFF, 5, 0, 0, 1), -1, 0);
    chk("R1 5-bit rx", rx_data, 8'h1F);
    do_read();

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule